// File: doc/BRIEF.md
# Transition Recorder

The transition recorder watches a parallel input bus and turns its activity into a compact stream of fixed-width words. A word is produced only when the bus takes a value different from the one most recently recorded; each word carries the new bus value together with the number of clocks elapsed since the previous word. When the bus is quiet, the block emits a keep-alive word each time its elapsed-clock counter wraps. A long idle stretch therefore costs one word per wrap period instead of one word per clock.

Software or a controller pulses `start` with a base address and a mode selection. Words leave through a valid/ready port with a one-deep holding register, and each word is tagged with the memory address it should be written to. Two word formats exist. The basic format holds a full-width timestamp. The extended format spends bit 0 on a flag that marks idle words, and an idle word covers a much longer span. A `stop` pulse ends capture, and `busy` stays high until the last held word has been taken.

Top module: `transition_recorder`

## Requirements
- R1: After reset, `out_valid`, `busy` and `overflow` are 0 and `out_addr` is 0.
- R2: A `start` pulse while `busy` is 0 puts the word {`sample_in`, all-zero time field} on the output one cycle later, at address `base_addr`. The same pulse clears `overflow` and latches `ext_mode` for the run. A `start` while `busy` is 1 has no effect on the address, the words or the mode.
- R3: While running, a word is produced in the cycle after the sampled bus differs from the last recorded value. Bits [REC_W-1:STAMP_W] hold the new value. In basic mode (`ext_mode`=0), bits [STAMP_W-1:0] hold the number of clocks since the previous word, modulo 2^STAMP_W.
- R4: In basic mode, when 2^STAMP_W clocks pass after a word with no change, a word {last value, all-zero time} is produced. A static bus therefore yields exactly one word every 2^STAMP_W clocks.
- R5: In extended mode, a change word has bit 0 equal to 0, and bits [STAMP_W-1:1] hold the low STAMP_W-1 bits of the clocks elapsed since the previous word.
- R6: In extended mode, when 2^(REC_W-1) clocks pass after a word with no change, an idle word is produced. It has bit 0 equal to 1, and its 31-bit count field (bits [REC_W-1:1]) is all zero, meaning one full wrap.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged.
- R8: Each accepted word (`out_valid` and `out_ready` both 1) advances `out_addr` by one.
- R9: A word that becomes due while the held word is not accepted is dropped and sets `overflow`, which stays 1 until the next accepted `start`. The recorded value and the counter still advance as if the word had been sent.
- R10: After a `stop` pulse, no new words are produced; a change in the stop cycle itself produces none. A held word still drains, and `busy` stays 1 until it has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| stop | input | 1 | End the run |
| ext_mode | input | 1 | 1 selects the extended idle format for the run |
| base_addr | input | ADDR_W | Address of the first word of a run |
| sample_in | input | SAMPLE_W | Monitored bus, already synchronous |
| out_ready | input | 1 | Sink accepts the held word |
| out_valid | output | 1 | A word is held |
| out_data | output | REC_W | Held word |
| out_addr | output | ADDR_W | Address for the held word |
| busy | output | 1 | Running or a word still held |
| overflow | output | 1 | Sticky: a word was dropped |

## Verification
A stale last-value register shows up as a word appearing on the very next cycle after a non-change, or as a missing word after a real change. A miscounted interval shows up in the time field of the next word, or as a keep-alive word that lands early or late by a countable number of clocks. A lost handshake or address step shows up in `out_addr` on the following cycle. Overflow and stop faults show up as a wrong `overflow` or `busy` level within one cycle of the back-pressured or stopped event.

// File: rtl/tr_pkg.sv
package tr_pkg;
   typedef enum logic [1:0] {
      KIND_NONE   = 2'd0,
      KIND_START  = 2'd1,
      KIND_CHANGE = 2'd2,
      KIND_IDLE   = 2'd3
   } rec_kind_t;
endpackage

// File: rtl/tr_interval_ctr.sv
module tr_interval_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             advance,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (restart)
         count <= CNT_W'(1);
      else if (advance)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/tr_pack.sv
module tr_pack
   import tr_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int STAMP_W  = 16,
   parameter int EXT_EN   = 1,
   parameter int CNT_W    = 31,
   localparam int REC_W   = SAMPLE_W + STAMP_W
) (
   input  rec_kind_t         kind,
   input  logic              ext,
   input  logic [SAMPLE_W-1:0] now_val,
   input  logic [SAMPLE_W-1:0] held_val,
   input  logic [CNT_W-1:0]  elapsed,
   output logic [REC_W-1:0]  word
);
   logic [REC_W-1:0] basic_word;

   always_comb begin
      case (kind)
         KIND_START:  basic_word = {now_val, {STAMP_W{1'b0}}};
         KIND_CHANGE: basic_word = {now_val, elapsed[STAMP_W-1:0]};
         KIND_IDLE:   basic_word = {held_val, {STAMP_W{1'b0}}};
         default:     basic_word = '0;
      endcase
   end

   generate
      if (EXT_EN != 0) begin : g_ext
         logic [REC_W-1:0] ext_word;
         always_comb begin
            case (kind)
               KIND_START:  ext_word = {now_val, {STAMP_W{1'b0}}};
               KIND_CHANGE: ext_word = {now_val, elapsed[STAMP_W-2:0], 1'b0};
               KIND_IDLE:   ext_word = {{(REC_W-1){1'b0}}, 1'b1};
               default:     ext_word = '0;
            endcase
         end
         assign word = ext ? ext_word : basic_word;
      end else begin : g_basic
         logic unused_ext;
         assign unused_ext = ext;
         assign word = basic_word;
      end
   endgenerate
endmodule

// File: rtl/tr_out_stage.sv
module tr_out_stage #(
   parameter int REC_W  = 32,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_req,
   input  logic [REC_W-1:0]  word_in,
   input  logic              rewind,
   input  logic [ADDR_W-1:0] rewind_addr,
   input  logic              ready,
   output logic              valid,
   output logic [REC_W-1:0]  word_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              dropped
);
   logic taken;
   logic can_load;

   assign taken    = valid && ready;
   assign can_load = !valid || ready;
   assign dropped  = load_req && !can_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         word_q <= '0;
      end else if (load_req && can_load) begin
         valid  <= 1'b1;
         word_q <= word_in;
      end else if (taken) begin
         valid  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (rewind)
         addr_q <= rewind_addr;
      else if (taken)
         addr_q <= addr_q + 1'b1;
   end
endmodule

// File: rtl/transition_recorder.sv
module transition_recorder
   import tr_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int STAMP_W  = 16,
   parameter int ADDR_W   = 12,
   parameter int EXT_EN   = 1,
   localparam int REC_W   = SAMPLE_W + STAMP_W,
   localparam int CNT_W   = (EXT_EN != 0) ? REC_W - 1 : STAMP_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                stop,
   input  logic                ext_mode,
   input  logic [ADDR_W-1:0]   base_addr,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                out_ready,
   output logic                out_valid,
   output logic [REC_W-1:0]    out_data,
   output logic [ADDR_W-1:0]   out_addr,
   output logic                busy,
   output logic                overflow
);
   initial begin
      assert (SAMPLE_W >= 1) else $fatal(1, "SAMPLE_W must be at least 1");
      assert (STAMP_W >= 2) else $fatal(1, "STAMP_W must be at least 2");
      assert (ADDR_W >= 1) else $fatal(1, "ADDR_W must be at least 1");
   end

   logic                run_q;
   logic                mode_q;
   logic [SAMPLE_W-1:0] last_q;
   logic [CNT_W-1:0]    elapsed;
   logic                start_ok;
   logic                live;
   logic                changed;
   logic                wrapped;
   logic                idle_due;
   logic                word_due;
   logic                dropped;
   rec_kind_t           kind;
   logic [REC_W-1:0]    word;

   assign busy     = run_q || out_valid;
   assign start_ok = start && !busy;
   assign live     = run_q && !stop;
   assign changed  = live && (sample_in != last_q);
   assign idle_due = live && !changed && wrapped;
   assign word_due = start_ok || changed || idle_due;

   generate
      if (EXT_EN != 0) begin : g_mode
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mode_q <= 1'b0;
            else if (start_ok)
               mode_q <= ext_mode;
         end
         assign wrapped = mode_q ? (elapsed == '0)
                                 : (elapsed[STAMP_W-1:0] == '0);
      end else begin : g_nomode
         logic unused_mode;
         assign unused_mode = ext_mode;
         assign mode_q  = 1'b0;
         assign wrapped = (elapsed == '0);
      end
   endgenerate

   always_comb begin
      if (start_ok)
         kind = KIND_START;
      else if (changed)
         kind = KIND_CHANGE;
      else if (idle_due)
         kind = KIND_IDLE;
      else
         kind = KIND_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= 1'b0;
      else if (start_ok)
         run_q <= 1'b1;
      else if (stop)
         run_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_q <= '0;
      else if (start_ok || changed)
         last_q <= sample_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         overflow <= 1'b0;
      else if (start_ok)
         overflow <= 1'b0;
      else if (dropped)
         overflow <= 1'b1;
   end

   tr_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (word_due),
      .advance (run_q),
      .count   (elapsed)
   );

   tr_pack #(
      .SAMPLE_W (SAMPLE_W),
      .STAMP_W  (STAMP_W),
      .EXT_EN   (EXT_EN),
      .CNT_W    (CNT_W)
   ) u_pack (
      .kind     (kind),
      .ext      (mode_q),
      .now_val  (sample_in),
      .held_val (last_q),
      .elapsed  (elapsed),
      .word     (word)
   );

   tr_out_stage #(.REC_W(REC_W), .ADDR_W(ADDR_W)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_req    (word_due),
      .word_in     (word),
      .rewind      (start_ok),
      .rewind_addr (base_addr),
      .ready       (out_ready),
      .valid       (out_valid),
      .word_q      (out_data),
      .addr_q      (out_addr),
      .dropped     (dropped)
   );
endmodule

// File: rtl/tr_checker.sv
module tr_checker #(
   parameter int REC_W  = 32,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              run_q,
   input logic              mode_q,
   input logic              out_valid,
   input logic              out_ready,
   input logic [REC_W-1:0]  out_data,
   input logic [ADDR_W-1:0] out_addr,
   input logic              overflow
);
   // R7: a held word neither vanishes nor changes while refused
   a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R8: every accepted word moves the address on by one
   a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (out_addr == ADDR_W'($past(out_addr) + 1'b1)));

   // R9: overflow survives until an accepted start
   a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !(start && !busy)) |=> overflow);

   // R6: an extended idle word carries only the flag bit
   a_r6_idle_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && out_valid && out_data[0]) |-> (out_data[REC_W-1:1] == '0));

   // R10: once stopped and drained, no word appears without a start
   a_r10_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !out_valid && !start) |=> !out_valid);
endmodule

bind transition_recorder tr_checker #(.REC_W(REC_W), .ADDR_W(ADDR_W)) u_tr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .run_q     (run_q),
   .mode_q    (mode_q),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_addr  (out_addr),
   .overflow  (overflow)
);

// File: tb/transition_recorder_bench.sv
`timescale 1ns/1ps
module transition_recorder_bench;
   localparam int SW = 8;
   localparam int TW = 8;
   localparam int AW = 6;
   localparam int RW = SW + TW;
   localparam int CW = RW - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          stop = 1'b0;
   logic          ext_mode = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [SW-1:0] sample_in = '0;
   logic          out_ready = 1'b0;
   logic          out_valid;
   logic [RW-1:0] out_data;
   logic [AW-1:0] out_addr;
   logic          busy;
   logic          overflow;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // independent model state
   logic          m_run, m_mode, m_v, m_ovf;
   logic [SW-1:0] m_last;
   logic [CW-1:0] m_cnt;
   logic [RW-1:0] m_data;
   logic [AW-1:0] m_addr;

   always #2 clk = ~clk;

   transition_recorder #(.SAMPLE_W(SW), .STAMP_W(TW), .ADDR_W(AW), .EXT_EN(1))
   u_transition_recorder (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .ext_mode(ext_mode),
      .base_addr(base_addr), .sample_in(sample_in), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data), .out_addr(out_addr),
      .busy(busy), .overflow(overflow)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_run = 0; m_mode = 0; m_v = 0; m_ovf = 0;
      m_last = '0; m_cnt = '0; m_data = '0; m_addr = '0;
   endtask

   // one clock: drive at negedge, advance the model, compare after the edge
   task automatic step(input logic [SW-1:0] s, input logic rdy, input logic st,
                       input logic sp, input string tag);
      logic mb, sacc, er, chg, wr, hs, due;
      logic [RW-1:0] rec;
      @(negedge clk);
      sample_in = s; out_ready = rdy; start = st; stop = sp;
      mb   = m_run || m_v;
      sacc = st && !mb;
      er   = m_run && !sp;
      chg  = er && (s != m_last);
      wr   = er && !chg && (m_mode ? (m_cnt == '0) : (m_cnt[TW-1:0] == '0));
      hs   = m_v && rdy;
      due  = sacc || chg || wr;
      if (sacc)       rec = {s, {TW{1'b0}}};
      else if (chg)   rec = m_mode ? {s, m_cnt[TW-2:0], 1'b0} : {s, m_cnt[TW-1:0]};
      else            rec = m_mode ? RW'(1) : {m_last, {TW{1'b0}}};
      @(posedge clk);
      if (sacc) m_addr = base_addr; else if (hs) m_addr = m_addr + 1'b1;
      if (due && (!m_v || rdy)) begin m_v = 1; m_data = rec; end
      else if (hs) m_v = 0;
      else if (due) m_ovf = 1;
      if (sacc) m_ovf = 0;
      if (due) m_cnt = CW'(1); else if (m_run) m_cnt = m_cnt + 1'b1;
      if (sacc || chg) m_last = s;
      if (sacc) begin m_run = 1; m_mode = ext_mode; end
      else if (sp) m_run = 0;
      #1;
      start = 0; stop = 0;
      check(out_valid == m_v, tag, "out_valid", out_valid, m_v);
      if (m_v) check(out_data == m_data, tag, "out_data", out_data, m_data);
      check(out_addr == m_addr, tag, "out_addr", out_addr, m_addr);
      check(overflow == m_ovf, tag, "overflow", overflow, m_ovf);
      check(busy == (m_run || m_v), tag, "busy", busy, m_run || m_v);
   endtask

   task automatic stop_and_drain();
      step(sample_in, 1'b1, 1'b0, 1'b1, "R10");
      step(sample_in, 1'b1, 1'b0, 1'b0, "R10");
   endtask

   task automatic t_reset();
      model_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      check(out_valid == 0, "R1", "out_valid", out_valid, 0);
      check(busy == 0, "R1", "busy", busy, 0);
      check(overflow == 0, "R1", "overflow", overflow, 0);
      check(out_addr == 0, "R1", "out_addr", out_addr, 0);
   endtask

   task automatic t_basic_changes();
      ext_mode = 0; base_addr = 6'd5;
      step(8'h3C, 1, 1, 0, "R2");
      check(out_data == 16'h3C00, "R2", "start word", out_data, 16'h3C00);
      check(out_addr == 6'd5, "R2", "base address", out_addr, 5);
      step(8'h3C, 1, 0, 0, "R3");
      step(8'h3C, 1, 0, 0, "R3");
      step(8'h41, 1, 0, 0, "R3");
      check(out_valid && out_data == 16'h4103, "R3", "gap of 3", out_data, 16'h4103);
      step(8'h42, 1, 0, 0, "R3");
      check(out_data == 16'h4201, "R3", "gap of 1", out_data, 16'h4201);
      step(8'h42, 1, 0, 0, "R3");
      check(out_valid == 0, "R3", "no word without change", out_valid, 0);
      base_addr = 6'd40;
      step(8'h42, 1, 1, 0, "R2");
      check(out_valid == 0 && out_addr != 6'd40, "R2", "start while busy", out_addr, 8);
      for (int i = 0; i < 20; i++) step(8'(i * 37), 1, 0, 0, "R3");
      stop_and_drain();
   endtask

   task automatic t_basic_idle();
      int seen;
      ext_mode = 0; base_addr = 6'd0;
      step(8'h9A, 1, 1, 0, "R4");
      seen = 0;
      for (int i = 0; i < 600; i++) begin
         step(8'h9A, 1, 0, 0, "R4");
         if (out_valid) begin
            seen++;
            check(out_data == 16'h9A00, "R4", "idle word", out_data, 16'h9A00);
            check(i == 255 || i == 511, "R4", "idle spacing", i, 256 * seen - 1);
         end
      end
      check(seen == 2, "R4", "idle count", seen, 2);
      stop_and_drain();
   endtask

   task automatic t_ext();
      int seen;
      ext_mode = 1; base_addr = 6'd10;
      step(8'h11, 1, 1, 0, "R5");
      for (int i = 0; i < 4; i++) step(8'h11, 1, 0, 0, "R5");
      step(8'h22, 1, 0, 0, "R5");
      check(out_data == {8'h22, 7'd5, 1'b0}, "R5", "ext change", out_data, {8'h22, 7'd5, 1'b0});
      for (int i = 0; i < 200; i++) step(8'h22, 1, 0, 0, "R5");
      step(8'h23, 1, 0, 0, "R5");
      check(out_data[0] == 0 && out_data[7:1] == 7'(201), "R5", "ext delta low bits",
            out_data, {8'h23, 7'(201), 1'b0});
      seen = 0;
      for (int i = 0; i < 32800; i++) begin
         step(8'h23, 1, 0, 0, "R6");
         if (out_valid) begin
            seen++;
            check(out_data == 16'h0001 && i == 32767, "R6", "ext idle word", out_data, 1);
         end
      end
      check(seen == 1, "R6", "ext idle count", seen, 1);
      stop_and_drain();
   endtask

   task automatic t_backpressure();
      logic [SW-1:0] s;
      logic [AW-1:0] a0;
      ext_mode = 0; base_addr = 6'd60;
      s = 8'h01;
      step(s, 0, 1, 0, "R7");
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 3) == 0) s = 8'($urandom);
         step(s, ($urandom_range(0, 2) != 0), 0, 0, (i % 2) ? "R7" : "R8");
      end
      a0 = out_addr;
      step(s, 0, 0, 0, "R8");
      check(out_addr == a0, "R8", "address held", out_addr, a0);
      stop_and_drain();
   endtask

   task automatic t_overflow_stop();
      ext_mode = 0; base_addr = 6'd2;
      step(8'h50, 0, 1, 0, "R9");
      step(8'h51, 0, 0, 0, "R9");
      check(overflow == 1, "R9", "overflow set", overflow, 1);
      step(8'h52, 0, 0, 0, "R9");
      check(out_data == 16'h5000, "R9", "held word kept", out_data, 16'h5000);
      step(8'h52, 0, 0, 1, "R10");
      check(busy == 1, "R10", "busy while held", busy, 1);
      step(8'h77, 0, 0, 0, "R10");
      step(8'h78, 1, 0, 0, "R10");
      check(busy == 0 && out_valid == 0, "R10", "drained", busy, 0);
      check(overflow == 1, "R9", "overflow sticky", overflow, 1);
      step(8'h79, 1, 0, 0, "R10");
      check(out_valid == 0, "R10", "no word after stop", out_valid, 0);
      step(8'h79, 1, 1, 0, "R9");
      check(overflow == 0, "R9", "start clears overflow", overflow, 0);
      step(8'h80, 1, 0, 1, "R10");
      check(out_valid == 0, "R10", "change in stop cycle", out_valid, 0);
      step(8'h80, 1, 0, 0, "R10");
   endtask

   initial begin
      t_reset();
      t_basic_changes();
      t_basic_idle();
      t_ext();
      t_backpressure();
      t_overflow_stop();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(4 * 190000);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule